// File: doc/BRIEF.md
# I2C Byte Channel with Address Wake-Up

This block is a byte-oriented channel for a two-wire I2C bus. Both lines are brought in through synchronizers. The block watches for start and stop conditions and counts SCL rising edges within each byte. It shifts received bits in, MSB first, and can shift a written byte out on SDA. It drives or checks the acknowledge slot. A single sticky interrupt marks the end of each byte, either at the eighth or at the ninth SCL rising edge. When a hold is selected, the block keeps SCL low at that point until software releases it.

In wake-up mode, the interrupt is raised only for the first byte after a start, and only if its seven address bits equal the programmed slave address. This lets a sleeping host ignore all traffic meant for other devices. Register access is reduced to write strobes and status outputs. The pads are open-drain, so the outputs only say when the device pulls a line low. Clock generation and arbitration are left to other logic.

Top module: `i2c_wake_chan`

## Requirements
- R1: A falling SDA while SCL is high is a start condition. It sets start_det_o, clears stop_det_o and resets the bit count, so the next eight bits form the address byte.
- R2: A rising SDA while SCL is high is a stop condition. It sets stop_det_o and clears start_det_o.
- R3: With ack_chk_en_i high, SDA low at the ninth SCL rising edge of a byte sets ack_det_o. With ack_chk_en_i low, ack_det_o stays clear.
- R4: Bits are sampled on SCL rising edges, MSB first. rx_data_o holds the full byte from the eighth rising edge of that byte onward.
- R5: With wake_en_i low, irq_o is set at the eighth rising edge when wait_sel_i[0]=0 and at the ninth when wait_sel_i[0]=1. It is not set earlier in the byte.
- R6: With wake_en_i high, irq_o is set at the selected edge only for the first byte after a start whose bits [7:1] equal slave_addr_i. Mismatching address bytes and data bytes raise nothing.
- R7: With wait_sel_i[1]=1, scl_oe_o goes high when the interrupt is set. It stays high until a release_wait_i pulse.
- R8: wr_shift_i with enable_i high loads wr_data_i. While a byte is loaded, sda_oe_o equals the inverted current bit, starting with the MSB; the next bit appears after each SCL fall that follows a rise. After eight bits the line is released. A write with enable_i low is ignored. A write during a hold starts only after release_wait_i.
- R9: With ack_gen_en_i high and no byte being sent, sda_oe_o is high from the SCL fall after the eighth bit until the SCL fall after the ninth.
- R10: clr_irq_i clears irq_o. clr_status_i clears start_det_o, stop_det_o and ack_det_o. scl_force_low_i drives scl_oe_o high.
- R11: After reset all outputs are zero and both lines are treated as idle high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sda_i | input | 1 | SDA pad level |
| scl_i | input | 1 | SCL pad level |
| sda_oe_o | output | 1 | Pull SDA low |
| scl_oe_o | output | 1 | Pull SCL low |
| enable_i | input | 1 | Channel enable for shift writes |
| wait_sel_i | input | 2 | [1] hold SCL at byte end, [0] ninth-edge point |
| wake_en_i | input | 1 | Address-match wake-up mode |
| ack_chk_en_i | input | 1 | Enable acknowledge detection |
| ack_gen_en_i | input | 1 | Enable acknowledge generation |
| slave_addr_i | input | 7 | Own slave address |
| scl_force_low_i | input | 1 | Force SCL low |
| wr_shift_i | input | 1 | Shift register write strobe |
| wr_data_i | input | 8 | Byte to transmit |
| clr_irq_i | input | 1 | Clear interrupt |
| clr_status_i | input | 1 | Clear start, stop and ack flags |
| release_wait_i | input | 1 | Release SCL hold |
| irq_o | output | 1 | Byte interrupt flag |
| start_det_o | output | 1 | Start detected |
| stop_det_o | output | 1 | Stop detected |
| ack_det_o | output | 1 | Acknowledge detected |
| rx_data_o | output | 8 | Last received byte |

## Verification
The assertions assume that SDA changes while SCL is high only as a start or stop condition. They also assume that shift writes arrive while SCL is low, so a transmitted bit never moves during a high phase. The bench holds every line level for six clocks, which is well beyond the synchronizer delay. It changes SDA only in low phases, except inside its start and stop sequences, and it issues writes only between SCL phases with SCL low. Random bytes, addresses and mode bits are drawn inside these bus rules.

// File: rtl/i2c_wake_pkg.sv
package i2c_wake_pkg;
  localparam int unsigned NUM_LINES = 2;
  localparam int unsigned LINE_SDA  = 0;
  localparam int unsigned LINE_SCL  = 1;
  localparam int unsigned WSEL_NINTH = 0;  // interrupt at ninth rising edge
  localparam int unsigned WSEL_HOLD  = 1;  // hold SCL low at byte end
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned LINES  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] lines_i,
  output logic [LINES-1:0] lvl_o,
  output logic [LINES-1:0] prev_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES:0] pipe_q;
    // idle-high reset avoids a false edge after reset
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '1;
      else         pipe_q <= {pipe_q[STAGES-1:0], lines_i[g]};
    end
    assign lvl_o[g]  = pipe_q[STAGES-1];
    assign prev_o[g] = pipe_q[STAGES];
  end
endmodule

// File: rtl/i2c_cond_det.sv
module i2c_cond_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sda_i,
  input  logic sda_prev_i,
  input  logic scl_i,
  input  logic scl_prev_i,
  input  logic clr_status_i,
  output logic start_ev_o,
  output logic start_det_o,
  output logic stop_det_o
);
  logic scl_high, stop_ev;
  logic start_q, stop_q;

  assign scl_high   = scl_i & scl_prev_i;
  assign start_ev_o = scl_high & sda_prev_i & ~sda_i;
  assign stop_ev    = scl_high & ~sda_prev_i & sda_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      if (start_ev_o)                    start_q <= 1'b1;
      else if (stop_ev || clr_status_i)  start_q <= 1'b0;
      if (stop_ev)                       stop_q  <= 1'b1;
      else if (start_ev_o || clr_status_i) stop_q <= 1'b0;
    end
  end

  assign start_det_o = start_q;
  assign stop_det_o  = stop_q;

  a_r1_start_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_ev_o |=> start_det_o && !stop_det_o);
  a_r2_stop_clears_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_ev |=> stop_det_o && !start_det_o);
  a_r10_clear_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_status_i && !start_ev_o && !stop_ev |=> !start_det_o && !stop_det_o);
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_wake_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_i,
  input  logic              scl_prev_i,
  input  logic              start_ev_i,
  input  logic              enable_i,
  input  logic [1:0]        wait_sel_i,
  input  logic              wake_en_i,
  input  logic              ack_chk_en_i,
  input  logic              ack_gen_en_i,
  input  logic [ADDR_W-1:0] slave_addr_i,
  input  logic              wr_shift_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              clr_irq_i,
  input  logic              clr_status_i,
  input  logic              release_wait_i,
  output logic              irq_o,
  output logic              hold_o,
  output logic              ack_det_o,
  output logic              sda_oe_o,
  output logic [DATA_W-1:0] rx_data_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W + 2);
  localparam int unsigned TXN_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] ACK_POS   = CNT_W'(DATA_W + 1);
  localparam logic [TXN_W-1:0] TX_LAST   = TXN_W'(DATA_W - 1);

  logic scl_rise, scl_fall;
  logic [CNT_W-1:0] cnt_q, rise_cnt;
  logic first_q, addr_hit_q, hit_now;
  logic [DATA_W-1:0] rx_sh_q, rx_q, rx_byte_now;
  logic irq_pt, irq_set, irq_q, hold_q, ack_q, ack_drv_q;
  logic load_req;
  logic [DATA_W-1:0] tx_sh_q;
  logic tx_act_q, tx_pend_q, tx_ph_q;
  logic [TXN_W-1:0] tx_n_q;

  assign scl_rise = scl_i & ~scl_prev_i;
  assign scl_fall = ~scl_i & scl_prev_i;
  assign rise_cnt = (cnt_q == ACK_POS) ? CNT_W'(1) : cnt_q + 1'b1;
  assign rx_byte_now = {rx_sh_q[DATA_W-2:0], sda_i};
  assign hit_now  = first_q && (rx_byte_now[DATA_W-1 -: ADDR_W] == slave_addr_i);

  // bit position and address-byte tracking
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      first_q    <= 1'b0;
      rx_sh_q    <= '0;
      rx_q       <= '0;
      addr_hit_q <= 1'b0;
    end else if (start_ev_i) begin
      cnt_q   <= '0;
      first_q <= 1'b1;
    end else if (scl_rise) begin
      cnt_q <= rise_cnt;
      if (cnt_q == ACK_POS) first_q <= 1'b0;
      if (rise_cnt <= LAST_DATA) rx_sh_q <= rx_byte_now;
      if (rise_cnt == LAST_DATA) begin
        rx_q       <= rx_byte_now;
        addr_hit_q <= hit_now;
      end
    end
  end

  assign irq_pt  = scl_rise && (wait_sel_i[WSEL_NINTH] ? (rise_cnt == ACK_POS)
                                                       : (rise_cnt == LAST_DATA));
  assign irq_set = irq_pt && (!wake_en_i ||
                   (wait_sel_i[WSEL_NINTH] ? addr_hit_q : hit_now));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      hold_q <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      if (irq_set)        irq_q <= 1'b1;
      else if (clr_irq_i) irq_q <= 1'b0;
      if (irq_set && wait_sel_i[WSEL_HOLD]) hold_q <= 1'b1;
      else if (release_wait_i)              hold_q <= 1'b0;
      if (scl_rise && rise_cnt == ACK_POS && ack_chk_en_i && !sda_i) ack_q <= 1'b1;
      else if (clr_status_i)                                         ack_q <= 1'b0;
    end
  end

  // transmit path
  assign load_req = wr_shift_i && enable_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sh_q   <= '0;
      tx_act_q  <= 1'b0;
      tx_pend_q <= 1'b0;
      tx_ph_q   <= 1'b0;
      tx_n_q    <= '0;
    end else if (load_req) begin
      tx_sh_q <= wr_data_i;
      tx_n_q  <= '0;
      tx_ph_q <= 1'b0;
      if (hold_q && !release_wait_i) begin
        tx_pend_q <= 1'b1;
        tx_act_q  <= 1'b0;
      end else begin
        tx_pend_q <= 1'b0;
        tx_act_q  <= 1'b1;
      end
    end else if (release_wait_i && tx_pend_q) begin
      tx_pend_q <= 1'b0;
      tx_act_q  <= 1'b1;
    end else if (tx_act_q) begin
      if (scl_rise) tx_ph_q <= 1'b1;
      else if (scl_fall && tx_ph_q) begin
        tx_ph_q <= 1'b0;
        if (tx_n_q == TX_LAST) tx_act_q <= 1'b0;
        else begin
          tx_n_q  <= tx_n_q + 1'b1;
          tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  // acknowledge generation for received bytes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    ack_drv_q <= 1'b0;
    else if (start_ev_i)                            ack_drv_q <= 1'b0;
    else if (scl_fall && cnt_q == LAST_DATA)        ack_drv_q <= ack_gen_en_i && !tx_act_q;
    else if (scl_fall && cnt_q == ACK_POS)          ack_drv_q <= 1'b0;
  end

  assign irq_o     = irq_q;
  assign hold_o    = hold_q;
  assign ack_det_o = ack_q;
  assign rx_data_o = rx_q;
  assign sda_oe_o  = (tx_act_q & ~tx_sh_q[DATA_W-1]) | ack_drv_q;

  a_r4_count_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= ACK_POS);
  a_r5_irq_on_scl_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $past(scl_rise));
  a_r6_wake_first_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) && $past(wake_en_i) |-> $past(first_q));
  a_r7_hold_needs_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_q) |-> $past(wait_sel_i[WSEL_HOLD]) && $past(irq_pt));
  a_r3_ack_in_ack_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_q) |-> cnt_q == ACK_POS);
  a_r8_tx_bit_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_act_q && $past(tx_act_q) && scl_i && scl_prev_i && !$past(load_req)
    |-> $stable(tx_sh_q[DATA_W-1]));
  a_r8_no_tx_while_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_act_q && tx_pend_q));
endmodule

// File: rtl/i2c_wake_chan.sv
module i2c_wake_chan
  import i2c_wake_pkg::*;
#(
  parameter int unsigned ADDR_W      = 7,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_i,
  output logic              sda_oe_o,
  output logic              scl_oe_o,
  input  logic              enable_i,
  input  logic [1:0]        wait_sel_i,
  input  logic              wake_en_i,
  input  logic              ack_chk_en_i,
  input  logic              ack_gen_en_i,
  input  logic [ADDR_W-1:0] slave_addr_i,
  input  logic              scl_force_low_i,
  input  logic              wr_shift_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              clr_irq_i,
  input  logic              clr_status_i,
  input  logic              release_wait_i,
  output logic              irq_o,
  output logic              start_det_o,
  output logic              stop_det_o,
  output logic              ack_det_o,
  output logic [DATA_W-1:0] rx_data_o
);
  logic [NUM_LINES-1:0] raw, lvl, prev;
  logic start_ev, hold;

  assign raw[LINE_SDA] = sda_i;
  assign raw[LINE_SCL] = scl_i;

  i2c_line_sync #(.LINES(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .lines_i(raw), .lvl_o(lvl), .prev_o(prev)
  );

  i2c_cond_det u_cond (
    .clk_i, .rst_ni,
    .sda_i(lvl[LINE_SDA]), .sda_prev_i(prev[LINE_SDA]),
    .scl_i(lvl[LINE_SCL]), .scl_prev_i(prev[LINE_SCL]),
    .clr_status_i, .start_ev_o(start_ev),
    .start_det_o, .stop_det_o
  );

  i2c_byte_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eng (
    .clk_i, .rst_ni,
    .sda_i(lvl[LINE_SDA]), .scl_i(lvl[LINE_SCL]), .scl_prev_i(prev[LINE_SCL]),
    .start_ev_i(start_ev), .enable_i, .wait_sel_i, .wake_en_i,
    .ack_chk_en_i, .ack_gen_en_i, .slave_addr_i, .wr_shift_i, .wr_data_i,
    .clr_irq_i, .clr_status_i, .release_wait_i,
    .irq_o, .hold_o(hold), .ack_det_o, .sda_oe_o, .rx_data_o
  );

  assign scl_oe_o = hold | scl_force_low_i;

  a_r10_force_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_force_low_i |-> scl_oe_o);
endmodule

// File: tb/tb_i2c_wake_chan.sv
module tb_i2c_wake_chan;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, sda, scl, sda_oe, scl_oe, enable, wake, ack_chk, ack_gen;
  logic force_low, wr_shift, clr_irq, clr_status, release_wait;
  logic irq, start_det, stop_det, ack_det;
  logic [1:0] wait_sel;
  logic [6:0] slave_addr;
  logic [7:0] wr_data, rx_data;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  i2c_wake_chan dut (
    .clk_i(clk), .rst_ni(rst_n), .sda_i(sda), .scl_i(scl),
    .sda_oe_o(sda_oe), .scl_oe_o(scl_oe), .enable_i(enable),
    .wait_sel_i(wait_sel), .wake_en_i(wake), .ack_chk_en_i(ack_chk),
    .ack_gen_en_i(ack_gen), .slave_addr_i(slave_addr),
    .scl_force_low_i(force_low), .wr_shift_i(wr_shift), .wr_data_i(wr_data),
    .clr_irq_i(clr_irq), .clr_status_i(clr_status), .release_wait_i(release_wait),
    .irq_o(irq), .start_det_o(start_det), .stop_det_o(stop_det),
    .ack_det_o(ack_det), .rx_data_o(rx_data)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_irq(bit wk, bit sel9, bit first, logic [7:0] b,
                                 logic [6:0] sa, bit at9);
    bit ok = !wk || (first && b[7:1] == sa);
    return at9 ? ok : (ok && !sel9);
  endfunction

  task automatic step(); repeat (6) @(negedge clk); endtask
  task automatic bus_start(); sda = 1; scl = 1; step(); sda = 0; step(); scl = 0; step(); endtask
  task automatic bus_stop(); sda = 0; step(); scl = 1; step(); sda = 1; step(); endtask
  task automatic bit_rise(input bit b); sda = b; step(); scl = 1; step(); endtask
  task automatic bit_fall(); scl = 0; step(); endtask
  task automatic pulse_clr(); clr_irq = 1; clr_status = 1; @(negedge clk); clr_irq = 0; clr_status = 0; endtask
  task automatic pulse_rel(); release_wait = 1; @(negedge clk); release_wait = 0; step(); endtask
  task automatic write_tx(input logic [7:0] d); wr_data = d; wr_shift = 1; @(negedge clk); wr_shift = 0; step(); endtask

  // random address byte then data byte
  task automatic random_frame();
    bit wk, sel9, first, ackbit, ack_exp;
    logic [7:0] b;
    wk = 1'($urandom); sel9 = 1'($urandom); ack_chk = 1'($urandom);
    slave_addr = 7'($urandom);
    wake = wk; wait_sel = {1'b0, sel9}; ack_gen = 0;
    pulse_clr();
    ack_exp = 0;
    bus_start();
    check("R1 start flag", start_det, 1);
    check("R1 stop cleared", stop_det, 0);
    for (int n = 0; n < 2; n++) begin
      first = (n == 0);
      b = 8'($urandom);
      if (first && $urandom % 2 == 0) b[7:1] = slave_addr;
      ackbit = 1'($urandom);
      clr_irq = 1; @(negedge clk); clr_irq = 0;
      for (int k = 7; k >= 1; k--) begin
        bit_rise(b[k]);
        if (k == 1) check("R5 no early irq", irq, 0);
        bit_fall();
      end
      bit_rise(b[0]);
      check("R4 rx byte", rx_data, b);
      check(wk ? "R6 irq at 8th" : "R5 irq at 8th", irq,
            exp_irq(wk, sel9, first, b, slave_addr, 0));
      bit_fall();
      bit_rise(ackbit);
      ack_exp = ack_exp | (ack_chk && !ackbit);
      check(wk ? "R6 irq at 9th" : "R5 irq at 9th", irq,
            exp_irq(wk, sel9, first, b, slave_addr, 1));
      check("R3 ack flag", ack_det, ack_exp);
      bit_fall();
    end
    bus_stop();
    check("R2 stop flag", stop_det, 1);
    check("R2 start cleared", start_det, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] tx;
    void'($urandom(32'h1c2d));
    rst_n = 0; sda = 1; scl = 1; enable = 0; wake = 0; ack_chk = 0; ack_gen = 0;
    force_low = 0; wr_shift = 0; clr_irq = 0; clr_status = 0; release_wait = 0;
    wait_sel = 2'b00; slave_addr = 7'h29; wr_data = 0;
    repeat (4) @(negedge clk);
    rst_n = 1; step();
    // R11 reset state
    check("R11 irq", irq, 0);
    check("R11 flags", {start_det, stop_det, ack_det}, 0);
    check("R11 line drives", {sda_oe, scl_oe}, 0);
    check("R11 rx", rx_data, 0);

    // R10 force low and clear
    force_low = 1; @(negedge clk);
    check("R10 force scl", scl_oe, 1);
    force_low = 0; @(negedge clk);
    check("R10 force off", scl_oe, 0);
    bus_start();
    check("R1 start", start_det, 1);
    pulse_clr(); step();
    check("R10 clear status", start_det, 0);

    // R8 write ignored without enable
    enable = 0; write_tx(8'h00);
    check("R8 ignored when disabled", sda_oe, 0);
    enable = 1;

    // R7/R8 hold at 9th edge, deferred transmit
    wait_sel = 2'b11; wake = 0; ack_gen = 0;
    bus_start();
    tx = 8'h52;
    for (int k = 7; k >= 0; k--) begin bit_rise(tx[k]); bit_fall(); end
    check("R7 no hold before 9th", scl_oe, 0);
    bit_rise(1'b0);
    check("R7 hold at 9th", scl_oe, 1);
    check("R5 irq at 9th directed", irq, 1);
    bit_fall();
    check("R7 hold kept", scl_oe, 1);
    tx = 8'h5A;
    write_tx(tx);
    check("R8 deferred during hold", sda_oe, 0);
    pulse_rel();
    check("R7 released", scl_oe, 0);
    for (int k = 7; k >= 0; k--) begin
      bit_rise(tx[k]);
      check("R8 tx bit", sda_oe, !tx[k]);
      bit_fall();
    end
    check("R8 line released", sda_oe, 0);
    bus_stop();
    pulse_rel(); pulse_clr();

    // R9 acknowledge generation, R3 detection
    wait_sel = 2'b00; ack_gen = 1; ack_chk = 1;
    bus_start();
    tx = 8'hA0;
    for (int k = 7; k >= 1; k--) begin bit_rise(tx[k]); bit_fall(); end
    bit_rise(tx[0]);
    check("R9 no ack drive yet", sda_oe, 0);
    bit_fall();
    check("R9 ack drive", sda_oe, 1);
    bit_rise(1'b0);
    check("R9 ack held high", sda_oe, 1);
    check("R3 ack seen", ack_det, 1);
    bit_fall();
    check("R9 ack released", sda_oe, 0);
    bus_stop();

    for (int i = 0; i < 24; i++) random_frame();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule